// File: doc/BRIEF.md
# Host Bridge Address Window Register Bank

This block is the 32-bit control register bank of a host-to-peripheral-bus bridge. Software reaches it through a single-cycle request strobe with a word offset; read data comes back registered one cycle later. The bank holds a set of address-decode windows, each made of a low-decode word, a high-decode word and a remap word. It also holds an interrupt cause register with its two masks, a handful of plain storage words and a CPU configuration word.

Bit 12 of the configuration word selects the byte order of every access. When the bit is clear, write data is byte-reversed before it is stored, and read data is byte-reversed before it is returned. Window 0 is the I/O window. From its low and high values the bank drives a base address, a length and a valid flag, which the bridge's forwarding logic uses. Hardware event sources set cause bits through a dedicated input. Software can only clear cause bits, and bit 0 always summarises the others. Read-only words return fixed values, and writes to them are dropped.

Top module: `wrb_bank`

## Requirements
- R1: After reset the configuration word reads 0x00001000. Window i low reads 0x80+16*i, window i high reads 0x0F+16*i, and remap i reads the same value as low i.
- R2: While configuration bit 12 is 0, write data is byte-reversed before use and read data is byte-reversed before it is returned. While the bit is 1, data passes unchanged.
- R3: A write to window i low (offset 0x010+2*i) stores bits [14:0]. In the same cycle it loads bits [10:0] into remap i (offset 0x020+i).
- R4: Window high words (offset 0x011+2*i) keep only bits [6:0]. A direct write to a remap word keeps only bits [10:0] and leaves the low word unchanged.
- R5: io_win_valid is 1 exactly when low0[6:0] <= high0. When it is 1, io_win_base = low0 << 21 and io_win_len = (high0 + 1 - low0[6:0]) << 21. When it is 0, both are zero.
- R6: Both sync words (offsets 0x030, 0x031) always read 0xC000FFEE, and writes to them are ignored.
- R7: The error words read 0xFFFFFFFF (offset 0x038) and 0x000000FF (offset 0x039), and writes to them are ignored.
- R8: Bits [31:1] of cause_set set the matching cause bits (offset 0x040). A write ANDs the cause word with the write data, with bit 0 of the data taken as 1. A set arriving in the same cycle wins over the clear. Cause bit 0 always equals the OR of bits [31:1].
- R9: The interrupt mask (offset 0x041) keeps only the bits in 0x3C3FFFFE. The bus interrupt mask (offset 0x042) keeps only the bits in 0x03FFFFFE.
- R10: rsp_rdata takes the addressed value at the clock edge that ends a read request, and holds it until the next read.
- R11: Offsets that decode to no register read 0x00000000, and writes to them change nothing.
- R12: The storage words at offsets 0x050 upward keep all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word offset |
| req_wdata | input | 32 | Write data, bus byte order |
| cause_set | input | 31 | Hardware event pulses for cause bits [31:1] |
| rsp_rdata | output | 32 | Registered read data, bus byte order |
| io_win_base | output | 36 | I/O window base address |
| io_win_len | output | 29 | I/O window length in bytes |
| io_win_valid | output | 1 | I/O window is well formed |

## Verification
The I/O window calculation is swept over all 128 high values for a spread of low values whose upper bits vary. This separates the inclusive boundary (low equal to high) from the invalid case, and shows that the upper low bits reach the base but not the comparison. Accesses are repeated in both byte orders, so a missing or misplaced swap on either the write path or the read path shows up on its own. Cause-register sequences mix hardware sets with software clears, including both in the same cycle, to tell the clear-only rule and the summary bit apart.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    localparam int DW          = 32;
    localparam int LO_BITS     = 15;
    localparam int HI_BITS     = 7;
    localparam int REMAP_BITS  = 11;
    localparam int ENDIAN_BIT  = 12;

    localparam logic [DW-1:0] CFG_RESET   = 32'h0000_1000;
    localparam logic [DW-1:0] SYNC_VALUE  = 32'hC000_FFEE;
    localparam logic [DW-1:0] ERR0_VALUE  = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] ERR1_VALUE  = 32'h0000_00FF;
    localparam logic [DW-1:0] IMASK_KEEP  = 32'h3C3F_FFFE;
    localparam logic [DW-1:0] PMASK_KEEP  = 32'h03FF_FFFE;

    // Word offsets of each register group
    localparam int OFS_CFG   = 'h000;
    localparam int OFS_WIN   = 'h010;
    localparam int OFS_REMAP = 'h020;
    localparam int OFS_SYNC  = 'h030;
    localparam int OFS_ERR   = 'h038;
    localparam int OFS_CAUSE = 'h040;
    localparam int OFS_IMASK = 'h041;
    localparam int OFS_PMASK = 'h042;
    localparam int OFS_SCR   = 'h050;

    typedef enum logic [3:0] {
        K_NONE, K_CFG, K_WLO, K_WHI, K_REMAP, K_SYNC,
        K_ERR, K_CAUSE, K_IMASK, K_PMASK, K_SCR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    function automatic logic [DW-1:0] byte_rev(input logic [DW-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [LO_BITS-1:0] lo_reset(input int i);
        return LO_BITS'(32'h80 + 32'(16 * i));
    endfunction

    function automatic logic [HI_BITS-1:0] hi_reset(input int i);
        return HI_BITS'(32'h0F + 32'(16 * i));
    endfunction

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
    import wrb_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_WIN = 6,
    parameter int NUM_SCR = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(OFS_WIN);
    localparam logic [ADDR_W-1:0] WIN_HI   = ADDR_W'(OFS_WIN + 2 * NUM_WIN);
    localparam logic [ADDR_W-1:0] RMP_LO   = ADDR_W'(OFS_REMAP);
    localparam logic [ADDR_W-1:0] RMP_HI   = ADDR_W'(OFS_REMAP + NUM_WIN);
    localparam logic [ADDR_W-1:0] SCR_LO   = ADDR_W'(OFS_SCR);
    localparam logic [ADDR_W-1:0] SCR_HI   = ADDR_W'(OFS_SCR + NUM_SCR);

    logic [ADDR_W-1:0] rel_win;
    logic [ADDR_W-1:0] rel_rmp;
    logic [ADDR_W-1:0] rel_scr;

    always_comb begin
        rel_win  = addr - WIN_LO;
        rel_rmp  = addr - RMP_LO;
        rel_scr  = addr - SCR_LO;
        sel.kind = K_NONE;
        sel.idx  = '0;
        if (addr == ADDR_W'(OFS_CFG)) begin
            sel.kind = K_CFG;
        end else if (addr >= WIN_LO && addr < WIN_HI) begin
            sel.kind = rel_win[0] ? K_WHI : K_WLO;
            sel.idx  = 4'(rel_win >> 1);
        end else if (addr >= RMP_LO && addr < RMP_HI) begin
            sel.kind = K_REMAP;
            sel.idx  = 4'(rel_rmp);
        end else if (addr == ADDR_W'(OFS_SYNC) || addr == ADDR_W'(OFS_SYNC + 1)) begin
            sel.kind = K_SYNC;
        end else if (addr == ADDR_W'(OFS_ERR) || addr == ADDR_W'(OFS_ERR + 1)) begin
            sel.kind = K_ERR;
            sel.idx  = (addr == ADDR_W'(OFS_ERR)) ? 4'd0 : 4'd1;
        end else if (addr == ADDR_W'(OFS_CAUSE)) begin
            sel.kind = K_CAUSE;
        end else if (addr == ADDR_W'(OFS_IMASK)) begin
            sel.kind = K_IMASK;
        end else if (addr == ADDR_W'(OFS_PMASK)) begin
            sel.kind = K_PMASK;
        end else if (addr >= SCR_LO && addr < SCR_HI) begin
            sel.kind = K_SCR;
            sel.idx  = 4'(rel_scr);
        end
    end

endmodule

// File: rtl/wrb_window.sv
module wrb_window
    import wrb_pkg::*;
#(
    parameter int WIN_IDX = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_lo,
    input  logic                  we_hi,
    input  logic                  we_remap,
    input  logic [LO_BITS-1:0]    wd,
    output logic [LO_BITS-1:0]    lo_q,
    output logic [HI_BITS-1:0]    hi_q,
    output logic [REMAP_BITS-1:0] remap_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= lo_reset(WIN_IDX);
            hi_q    <= hi_reset(WIN_IDX);
            remap_q <= REMAP_BITS'(lo_reset(WIN_IDX));
        end else begin
            if (we_lo) begin
                lo_q    <= wd;
                remap_q <= wd[REMAP_BITS-1:0];
            end else if (we_remap) begin
                remap_q <= wd[REMAP_BITS-1:0];
            end
            if (we_hi) begin
                hi_q <= wd[HI_BITS-1:0];
            end
        end
    end

    // R3: a low write also loads the remap word
    a_r3_remap_follows: assert property (@(posedge clk) disable iff (rst)
        we_lo |=> (remap_q == $past(wd[REMAP_BITS-1:0])));

    // R4: a remap write leaves the low word alone
    a_r4_remap_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        (we_remap && !we_lo) |=> $stable(lo_q));

endmodule

// File: rtl/wrb_irq.sv
module wrb_irq
    import wrb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we_cause,
    input  logic          we_imask,
    input  logic          we_pmask,
    input  logic [DW-1:0] wd,
    input  logic [DW-1:1] cause_set,
    output logic [DW-1:0] cause_q,
    output logic [DW-1:0] imask_q,
    output logic [DW-1:0] pmask_q
);
    logic [DW-1:1] cleared;
    logic [DW-1:1] next_events;

    always_comb begin
        cleared     = we_cause ? (cause_q[DW-1:1] & wd[DW-1:1]) : cause_q[DW-1:1];
        next_events = cleared | cause_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            imask_q <= '0;
            pmask_q <= '0;
        end else begin
            cause_q <= {next_events, |next_events};
            if (we_imask) imask_q <= wd & IMASK_KEEP;
            if (we_pmask) pmask_q <= wd & PMASK_KEEP;
        end
    end

    // R8: summary bit tracks the event bits
    a_r8_summary: assert property (@(posedge clk) disable iff (rst)
        cause_q[0] == (|cause_q[DW-1:1]));

    // R8: without a set pulse no cause bit can rise
    a_r8_clear_only: assert property (@(posedge clk) disable iff (rst)
        (cause_set == '0) |=> ((cause_q[DW-1:1] & ~$past(cause_q[DW-1:1])) == '0));

    // R9: masks never hold bits outside their keep pattern
    a_r9_mask_bits: assert property (@(posedge clk) disable iff (rst)
        ((imask_q & ~IMASK_KEEP) == '0) && ((pmask_q & ~PMASK_KEEP) == '0));

endmodule

// File: rtl/wrb_iowin.sv
module wrb_iowin
    import wrb_pkg::*;
#(
    parameter int WIN_SHIFT = 21,
    localparam int BASE_W   = LO_BITS + WIN_SHIFT,
    localparam int LEN_W    = HI_BITS + 1 + WIN_SHIFT
) (
    input  logic [LO_BITS-1:0] lo,
    input  logic [HI_BITS-1:0] hi,
    output logic [BASE_W-1:0]  base,
    output logic [LEN_W-1:0]   len,
    output logic               valid
);
    logic [HI_BITS:0] span;

    always_comb begin
        valid = (lo[HI_BITS-1:0] <= hi);
        span  = {1'b0, hi} + (HI_BITS+1)'(1) - {1'b0, lo[HI_BITS-1:0]};
        base  = valid ? {lo, {WIN_SHIFT{1'b0}}} : '0;
        len   = valid ? {span, {WIN_SHIFT{1'b0}}} : '0;
    end

endmodule

// File: rtl/wrb_bank.sv
module wrb_bank
    import wrb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WIN   = 6,
    parameter int NUM_SCR   = 4,
    parameter int WIN_SHIFT = 21,
    localparam int BASE_W   = LO_BITS + WIN_SHIFT,
    localparam int LEN_W    = HI_BITS + 1 + WIN_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW-1:1]     cause_set,
    output logic [DW-1:0]     rsp_rdata,
    output logic [BASE_W-1:0] io_win_base,
    output logic [LEN_W-1:0]  io_win_len,
    output logic              io_win_valid
);
    reg_sel_t             sel;
    logic [DW-1:0]        cfg_q;
    logic                 little;
    logic [DW-1:0]        wd_eff;
    logic                 wr;
    logic                 rd;
    logic [DW-1:0]        rd_val;
    logic [DW-1:0]        scr_q [NUM_SCR];
    logic [LO_BITS-1:0]   lo_q    [NUM_WIN];
    logic [HI_BITS-1:0]   hi_q    [NUM_WIN];
    logic [REMAP_BITS-1:0] remap_q [NUM_WIN];
    logic [DW-1:0]        cause_q;
    logic [DW-1:0]        imask_q;
    logic [DW-1:0]        pmask_q;

    assign little = cfg_q[ENDIAN_BIT];
    assign wr     = req_valid && req_write;
    assign rd     = req_valid && !req_write;
    assign wd_eff = little ? req_wdata : byte_rev(req_wdata);

    wrb_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .NUM_SCR(NUM_SCR)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    always_ff @(posedge clk) begin
        if (rst)                          cfg_q <= CFG_RESET;
        else if (wr && sel.kind == K_CFG) cfg_q <= wd_eff;
    end

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            wrb_window #(.WIN_IDX(i)) u_win (
                .clk      (clk),
                .rst      (rst),
                .we_lo    (wr && sel.kind == K_WLO   && sel.idx == 4'(i)),
                .we_hi    (wr && sel.kind == K_WHI   && sel.idx == 4'(i)),
                .we_remap (wr && sel.kind == K_REMAP && sel.idx == 4'(i)),
                .wd       (wd_eff[LO_BITS-1:0]),
                .lo_q     (lo_q[i]),
                .hi_q     (hi_q[i]),
                .remap_q  (remap_q[i])
            );
        end
        for (genvar s = 0; s < NUM_SCR; s++) begin : g_scr
            always_ff @(posedge clk) begin
                if (rst)                                            scr_q[s] <= '0;
                else if (wr && sel.kind == K_SCR && sel.idx == 4'(s)) scr_q[s] <= wd_eff;
            end
        end
    endgenerate

    wrb_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .we_cause  (wr && sel.kind == K_CAUSE),
        .we_imask  (wr && sel.kind == K_IMASK),
        .we_pmask  (wr && sel.kind == K_PMASK),
        .wd        (wd_eff),
        .cause_set (cause_set),
        .cause_q   (cause_q),
        .imask_q   (imask_q),
        .pmask_q   (pmask_q)
    );

    wrb_iowin #(.WIN_SHIFT(WIN_SHIFT)) u_iowin (
        .lo    (lo_q[0]),
        .hi    (hi_q[0]),
        .base  (io_win_base),
        .len   (io_win_len),
        .valid (io_win_valid)
    );

    always_comb begin
        rd_val = '0;
        case (sel.kind)
            K_CFG:   rd_val = cfg_q;
            K_SYNC:  rd_val = SYNC_VALUE;
            K_ERR:   rd_val = (sel.idx == 4'd0) ? ERR0_VALUE : ERR1_VALUE;
            K_CAUSE: rd_val = cause_q;
            K_IMASK: rd_val = imask_q;
            K_PMASK: rd_val = pmask_q;
            K_WLO, K_WHI, K_REMAP: begin
                for (int i = 0; i < NUM_WIN; i++) begin
                    if (sel.idx == 4'(i)) begin
                        if (sel.kind == K_WLO)      rd_val = DW'(lo_q[i]);
                        else if (sel.kind == K_WHI) rd_val = DW'(hi_q[i]);
                        else                        rd_val = DW'(remap_q[i]);
                    end
                end
            end
            K_SCR: begin
                for (int s = 0; s < NUM_SCR; s++) begin
                    if (sel.idx == 4'(s)) rd_val = scr_q[s];
                end
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rsp_rdata <= '0;
        else if (rd) rsp_rdata <= little ? rd_val : byte_rev(rd_val);
    end

    // R10: read data only moves on a read request
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rsp_rdata));

    // R6: sync read in native order returns the fixed pattern
    a_r6_sync_value: assert property (@(posedge clk) disable iff (rst)
        (rd && sel.kind == K_SYNC && little) |=> (rsp_rdata == SYNC_VALUE));

    // R2: a sync read in reversed order returns the swapped pattern
    a_r2_sync_swapped: assert property (@(posedge clk) disable iff (rst)
        (rd && sel.kind == K_SYNC && !little) |=> (rsp_rdata == byte_rev(SYNC_VALUE)));

    // R5: a valid window always has a nonzero length
    a_r5_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        io_win_valid |-> (io_win_len != '0));

endmodule

// File: tb/test_wrb_bank.sv
module test_wrb_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:1] cause_set = '0;
    logic [31:0] rsp_rdata;
    logic [35:0] io_win_base;
    logic [28:0] io_win_len;
    logic        io_win_valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    wrb_bank i_wrb_bank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cause_set(cause_set),
        .rsp_rdata(rsp_rdata), .io_win_base(io_win_base),
        .io_win_len(io_win_len), .io_win_valid(io_win_valid)
    );

    function automatic logic [31:0] rev32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(12'h000, rv); check("R1 cfg", rv, 32'h1000);
        for (int i = 0; i < 6; i++) begin
            rd(12'(12'h010 + 2 * i), rv); check("R1 low",   rv, 32'h80 + 16 * i);
            rd(12'(12'h011 + 2 * i), rv); check("R1 high",  rv, 32'h0F + 16 * i);
            rd(12'(12'h020 + i), rv);     check("R1 remap", rv, 32'h80 + 16 * i);
        end
        check("R5 reset valid", io_win_valid, 1);
        check("R5 reset base", io_win_base, 64'h80 << 21);
        check("R5 reset len",  io_win_len,  64'h10 << 21);

        // R3 low write feeds remap
        wr(12'h014, 32'hFFFF_FFFF);
        rd(12'h014, rv); check("R3 low mask", rv, 32'h7FFF);
        rd(12'h022, rv); check("R3 remap follows", rv, 32'h7FF);

        // R4 high and remap masks
        wr(12'h017, 32'hFFFF_FFFF);
        rd(12'h017, rv); check("R4 high mask", rv, 32'h7F);
        wr(12'h024, 32'hFFFF_FFFF);
        rd(12'h024, rv); check("R4 remap mask", rv, 32'h7FF);
        rd(12'h018, rv); check("R4 low untouched", rv, 32'hC0);

        // R6 sync words, R7 error words
        for (int k = 0; k < 2; k++) begin
            wr(12'(12'h030 + k), 32'h0);
            rd(12'(12'h030 + k), rv); check("R6 sync", rv, 32'hC000_FFEE);
        end
        wr(12'h038, 32'h0); wr(12'h039, 32'h0);
        rd(12'h038, rv); check("R7 err0", rv, 32'hFFFF_FFFF);
        rd(12'h039, rv); check("R7 err1", rv, 32'hFF);

        // R9 masks
        wr(12'h041, 32'hFFFF_FFFF); rd(12'h041, rv); check("R9 imask", rv, 32'h3C3F_FFFE);
        wr(12'h042, 32'hFFFF_FFFF); rd(12'h042, rv); check("R9 pmask", rv, 32'h03FF_FFFE);

        // R12 storage words, several patterns
        for (int s = 0; s < 4; s++) begin
            wr(12'(12'h050 + s), 32'hA5A5_0000 ^ (32'h1357_9BDF * (s + 1)));
        end
        for (int s = 0; s < 4; s++) begin
            rd(12'(12'h050 + s), rv);
            check("R12 storage", rv, 32'hA5A5_0000 ^ (32'h1357_9BDF * (s + 1)));
        end

        // R11 unmapped offsets
        wr(12'h0FF, 32'hFFFF_FFFF); wr(12'h7A3, 32'h1234_5678);
        rd(12'h0FF, rv); check("R11 unmapped read", rv, 0);
        rd(12'h7A3, rv); check("R11 unmapped read", rv, 0);
        rd(12'h050, rv); check("R11 no side effect", rv, 32'hA5A5_0000 ^ 32'h1357_9BDF);

        // R10 hold across idle cycles and writes
        rd(12'h041, rv);
        repeat (3) @(negedge clk);
        check("R10 hold idle", rsp_rdata, 32'h3C3F_FFFE);
        wr(12'h051, 32'h0);
        check("R10 hold after write", rsp_rdata, 32'h3C3F_FFFE);

        // R8 cause register
        @(negedge clk); cause_set = 31'h7878_0000; @(negedge clk); cause_set = '0;
        rd(12'h040, rv); check("R8 set", rv, 32'hF0F0_0001);
        wr(12'h040, 32'h0FFF_FFFE);
        rd(12'h040, rv); check("R8 clear keeps bit0 rule", rv, 32'h00F0_0001);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_wdata = 32'h0;
        cause_set = 31'h0000_0001;   // bit 1
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; cause_set = '0;
        rd(12'h040, rv); check("R8 set wins over clear", rv, 32'h0000_0003);
        wr(12'h040, 32'h0);
        rd(12'h040, rv); check("R8 all clear summary low", rv, 32'h0);

        // R2 reversed byte order
        wr(12'h000, 32'h0);
        rd(12'h000, rv); check("R2 cfg cleared", rv, 32'h0);
        wr(12'h052, 32'h1122_3344);
        rd(12'h052, rv); check("R2 round trip", rv, 32'h1122_3344);
        rd(12'h030, rv); check("R2 sync swapped", rv, rev32(32'hC000_FFEE));
        wr(12'h010, 32'h0500_0000);
        check("R2 swapped window write", io_win_base, 64'h5 << 21);
        wr(12'h000, 32'h0010_0000);
        rd(12'h000, rv); check("R2 cfg restored", rv, 32'h1000);
        rd(12'h052, rv); check("R2 stored swapped", rv, 32'h4433_2211);

        // R5 sweep of I/O window
        for (int l = 0; l < 128; l += 9) begin
            logic [14:0] lo;
            lo = 15'((l | (((l * 37) & 32'hFF) << 7)) & 32'h7FFF);
            wr(12'h010, 32'(lo));
            for (int h = 0; h < 128; h++) begin
                logic        ev;
                logic [63:0] eb, el;
                wr(12'h011, 32'(h));
                ev = (int'(lo & 15'h7F) <= h);
                eb = ev ? (64'(lo) << 21) : 64'h0;
                el = ev ? (64'(h + 1 - int'(lo & 15'h7F)) << 21) : 64'h0;
                check("R5 valid", io_win_valid, ev);
                check("R5 base", io_win_base, eb);
                check("R5 len", io_win_len, el);
            end
        end

        finish_run();
    end

endmodule